// File: doc/BRIEF.md
# Synchronous Rectifier Leg PWM with Dual Trip Latches

This block drives the two switches of a synchronous rectifier bridge leg so that together they behave like a diode. A free-running up-counter produces a reference phase. Two gate outputs follow that phase, with dead time inserted on both transitions. Two digital comparator flags from outside the block report the sign of the sensed current. The high-threshold flag means the current has gone negative, and it shuts off the high-side gate. The low-threshold flag means the current has gone positive, and it shuts off the low-side gate.

Each flag passes through a synchronizer and then sets its own trip latch. A set latch keeps its gate off until the latch is cleared. The two latches are cleared at different points in the cycle:
- The high-side latch is cleared during the high phase.
- The low-side latch is cleared during the low phase.

A blanking window follows every reference edge. While it is open, both flags are ignored. The clear for a side is applied on the cycle the window closes, not at the edge itself. As a result, noise near a switching edge cannot leave a latch set when blanking ends.

Top module: `sync_rect_pwm`

## Requirements
- R1: While `rst_n` is low, both gates and both trip status outputs are 0, and the counter restarts from 0 after release.
- R2: The counter counts 0 up to `period_i` and then returns to 0, giving a cycle of `period_i`+1 clocks. The reference phase is high while count < `duty_i`.
- R3: A phase's gate turns on only once the number of clocks since the last reference edge is at least `dead_i`. The gate then stays on until that phase ends. `gate_hi_o` belongs to the high phase and `gate_lo_o` to the low phase, so the two gates are never on together.
- R4: Each comparator flag passes through two synchronizing flops. A flag value applied before clock edge k can set its latch at edge k+2, and the status output shows the latch at once.
- R5: The high-threshold latch (`trip_hi_o`) forces `gate_hi_o` to 0 while it is set. The low-threshold latch (`trip_lo_o`) forces `gate_lo_o` to 0 while it is set. Each latch holds until its own clear.
- R6: During the first `blank_i` clocks of each phase, counted from the reference edge (age < `blank_i`), synchronized flags do not set either latch. The window ends early if the phase ends first.
- R7: The high latch is cleared on the high-phase clock whose age equals `blank_i`, and the low latch on the matching low-phase clock. If the phase ends before that age is reached, no clear happens in that phase.
- R8: When a set and a clear reach the same latch on the same clock, the latch ends that clock cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi_i | input | 1 | High-threshold comparator flag (asynchronous) |
| cmp_lo_i | input | 1 | Low-threshold comparator flag (asynchronous) |
| period_i | input | CNT_W | Last count value of the cycle |
| duty_i | input | CNT_W | Count at which the reference phase goes low |
| dead_i | input | DT_W | Dead time in clocks |
| blank_i | input | BLK_W | Blanking length in clocks |
| gate_hi_o | output | 1 | High-side gate drive |
| gate_lo_o | output | 1 | Low-side gate drive |
| trip_hi_o | output | 1 | High-threshold latch state |
| trip_lo_o | output | 1 | Low-threshold latch state |

## Verification
The bench builds the block with a 4-bit counter and 3-bit dead-time and blanking fields, so every cycle length stays short. It sweeps three periods, every duty value from 0 to beyond the period, and dead-time and blank lengths of 0, 2 and 5. This reaches phases shorter than the dead time or the blank window, zero-length phases, and clears that coincide with the edge. Four comparator patterns are used: both quiet, each flag held high alone, and both pseudo-random. Together they make sets, clears and same-cycle collisions happen on both latches throughout the cycle.

// File: rtl/srp_pkg.sv
package srp_pkg;
   localparam int SIDE_HI = 0;
   localparam int SIDE_LO = 1;
   localparam int N_SIDE  = 2;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("srp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/srp_timebase.sv
module srp_timebase #(
   parameter int CNT_W = 16,
   parameter int AGE_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] duty,
   output logic             ref_hi,
   output logic [AGE_W-1:0] age_now
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("srp_timebase: CNT_W must be at least 2");
   end
   if (AGE_W < 2) begin : g_bad_age
      $error("srp_timebase: AGE_W must be at least 2");
   end

   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             prev_q;
   logic [AGE_W-1:0] age_q;
   logic             edge_now;

   assign ref_hi   = (cnt_q < duty);
   assign edge_now = (ref_hi != prev_q);
   assign age_now  = edge_now ? '0 : age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         prev_q <= 1'b0;
         age_q  <= '0;
      end else begin
         cnt_q  <= (cnt_q >= period) ? '0 : cnt_q + CNT_W'(1);
         prev_q <= ref_hi;
         age_q  <= (age_now == AGE_MAX) ? AGE_MAX : age_now + AGE_W'(1);
      end
   end

   // R2: the count returns to zero after the last value of the cycle
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q >= period) |=> (cnt_q == '0));
endmodule

// File: rtl/srp_trip_latch.sv
module srp_trip_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic flag,
   input  logic blank,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              q <= 1'b0;
      else if (clr)            q <= 1'b0;
      else if (flag && !blank) q <= 1'b1;
   end

   p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !q);
   p_blank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (blank && !clr) |=> (q == $past(q)));
   p_set_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !blank && !clr) |=> q);
endmodule

// File: rtl/sync_rect_pwm.sv
module sync_rect_pwm #(
   parameter int CNT_W       = 16,
   parameter int DT_W        = 8,
   parameter int BLK_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_hi_i,
   input  logic             cmp_lo_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic [DT_W-1:0]  dead_i,
   input  logic [BLK_W-1:0] blank_i,
   output logic             gate_hi_o,
   output logic             gate_lo_o,
   output logic             trip_hi_o,
   output logic             trip_lo_o
);
   import srp_pkg::*;

   localparam int AGE_W = max2(DT_W, BLK_W) + 1;

   if (DT_W < 1 || BLK_W < 1) begin : g_bad_fields
      $error("sync_rect_pwm: DT_W and BLK_W must be at least 1");
   end

   logic             ref_hi;
   logic [AGE_W-1:0] age_now;
   logic [AGE_W-1:0] dead_ext;
   logic [AGE_W-1:0] blank_ext;
   logic             blank_act;
   logic [N_SIDE-1:0] cmp_in, cmp_s, clr, trip, gate;

   assign dead_ext  = AGE_W'(dead_i);
   assign blank_ext = AGE_W'(blank_i);
   assign blank_act = (age_now < blank_ext);
   assign cmp_in[SIDE_HI] = cmp_hi_i;
   assign cmp_in[SIDE_LO] = cmp_lo_i;

   srp_timebase #(.CNT_W(CNT_W), .AGE_W(AGE_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .period(period_i), .duty(duty_i),
      .ref_hi(ref_hi), .age_now(age_now)
   );

   for (genvar i = 0; i < N_SIDE; i++) begin : g_side
      logic in_phase;
      assign in_phase = (i == SIDE_HI) ? ref_hi : !ref_hi;
      assign clr[i]   = in_phase && (age_now == blank_ext);
      assign gate[i]  = rst_n && in_phase && (age_now >= dead_ext) && !trip[i];

      srp_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(cmp_in[i]), .q(cmp_s[i])
      );
      srp_trip_latch u_latch (
         .clk(clk), .rst_n(rst_n), .flag(cmp_s[i]), .blank(blank_act),
         .clr(clr[i]), .q(trip[i])
      );
   end

   assign gate_hi_o = gate[SIDE_HI];
   assign gate_lo_o = gate[SIDE_LO];
   assign trip_hi_o = trip[SIDE_HI];
   assign trip_lo_o = trip[SIDE_LO];

   // R7: high latch is empty right after the high-phase blank window closes
   p_hi_clear_point_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_hi && (age_now == blank_ext)) |=> !trip_hi_o);
endmodule

// File: tb/sim_sync_rect_pwm.sv
`timescale 1ns/1ps
module sim_sync_rect_pwm;
   localparam int CW = 4, DW = 3, BW = 3;

   logic clk = 1'b0, rst_n = 1'b0, cmp_hi = 1'b0, cmp_lo = 1'b0;
   logic [CW-1:0] period = '0, duty = '0;
   logic [DW-1:0] dead = '0;
   logic [BW-1:0] blank = '0;
   logic gate_hi, gate_lo, trip_hi, trip_lo;

   int checks = 0, fails = 0;
   int c_per, c_duty, c_dead, c_blank;
   int m_cnt, m_prev, m_age, m_s1h, m_s2h, m_s1l, m_s2l, m_th, m_tl;
   logic [7:0] lf = 8'hA5;

   always #2 clk = ~clk;

   sync_rect_pwm #(.CNT_W(CW), .DT_W(DW), .BLK_W(BW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cmp_hi_i(cmp_hi), .cmp_lo_i(cmp_lo),
      .period_i(period), .duty_i(duty), .dead_i(dead), .blank_i(blank),
      .gate_hi_o(gate_hi), .gate_lo_o(gate_lo),
      .trip_hi_o(trip_hi), .trip_lo_o(trip_lo)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s per=%0d duty=%0d dead=%0d blank=%0d actual=%0d expected=%0d",
                  tag, c_per, c_duty, c_dead, c_blank, act, exp);
      end
   endtask

   // Age of the current phase seen from model state (R2 phase, age since edge)
   task automatic phase_info(output int ph, output int age);
      ph  = (m_cnt < c_duty) ? 1 : 0;
      age = (ph != m_prev) ? 0 : m_age;
   endtask

   task automatic step_model(input int ph_hi_pin, input int ph_lo_pin);
      int ph, age, blk;
      phase_info(ph, age);
      blk = (age < c_blank) ? 1 : 0;
      // R7 clear points, R8 clear over set, R6 blanking, R4 sync depth
      if (ph == 1 && age == c_blank)      m_th = 0;
      else if (m_s2h == 1 && blk == 0)    m_th = 1;
      if (ph == 0 && age == c_blank)      m_tl = 0;
      else if (m_s2l == 1 && blk == 0)    m_tl = 1;
      m_s2h = m_s1h; m_s1h = ph_hi_pin;
      m_s2l = m_s1l; m_s1l = ph_lo_pin;
      m_cnt  = (m_cnt >= c_per) ? 0 : m_cnt + 1;
      m_prev = ph;
      m_age  = (age >= 1000) ? 1000 : age + 1;
   endtask

   task automatic compare_all();
      int ph, age, eh, el;
      phase_info(ph, age);
      eh = (ph == 1 && age >= c_dead && m_th == 0) ? 1 : 0;
      el = (ph == 0 && age >= c_dead && m_tl == 0) ? 1 : 0;
      check("R2 R3 R5 gate_hi", int'(gate_hi), eh);
      check("R2 R3 R5 gate_lo", int'(gate_lo), el);
      check("R4 R6 R7 R8 trip_hi", int'(trip_hi), m_th);
      check("R4 R6 R7 R8 trip_lo", int'(trip_lo), m_tl);
   endtask

   task automatic run_config(input int p, input int d, input int dt, input int bl, input int mode);
      int hp, lp;
      c_per = p; c_duty = d; c_dead = dt; c_blank = bl;
      @(negedge clk);
      rst_n = 1'b0; cmp_hi = 1'b0; cmp_lo = 1'b0;
      period = CW'(p); duty = CW'(d); dead = DW'(dt); blank = BW'(bl);
      @(negedge clk); @(negedge clk);
      // R1: reset state of gates and latches
      check("R1 gate_hi", int'(gate_hi), 0);
      check("R1 gate_lo", int'(gate_lo), 0);
      check("R1 trip_hi", int'(trip_hi), 0);
      check("R1 trip_lo", int'(trip_lo), 0);
      m_cnt = 0; m_prev = 0; m_age = 0;
      m_s1h = 0; m_s2h = 0; m_s1l = 0; m_s2l = 0; m_th = 0; m_tl = 0;
      rst_n = 1'b1;
      for (int k = 0; k < 3 * (p + 1) + 4; k++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         case (mode)
            0: begin hp = 0; lp = 0; end
            1: begin hp = 1; lp = 0; end
            2: begin hp = 0; lp = 1; end
            default: begin hp = int'(lf[0]); lp = int'(lf[3]); end
         endcase
         cmp_hi = hp[0]; cmp_lo = lp[0];
         step_model(hp, lp);
         @(negedge clk);
         compare_all();
      end
   endtask

   initial begin
      int idx;
      int pers[3]  = '{3, 7, 12};
      int vals[3]  = '{0, 2, 5};
      idx = 0;
      foreach (pers[a]) begin
         for (int d = 0; d <= pers[a] + 1; d++) begin
            for (int t = 0; t < 3; t++) begin
               for (int b = 0; b < 3; b++) begin
                  run_config(pers[a], d, vals[t], vals[b], idx % 4);
                  idx++;
               end
            end
         end
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule